// File: doc/BRIEF.md
# Guarded Displacement Load Unit

This block is a pipelined 32-bit load path for a wide-issue data path. It can accept one load operation on each clock cycle. An operation carries four things: a base register value, a 7-bit signed displacement counted in words, a guard word and the index of a destination register. The unit adds the scaled displacement to the base and reads the addressed word through a synchronous byte-addressed memory port. It then arranges the four bytes in little-endian or big-endian order, as chosen by a mode input, and places the result on a register-file write port.

Bit 0 of the guard decides whether the operation does anything. When it is clear, the operation starts no memory read and makes no register write. The byte-order mode is captured at issue, so every load in flight keeps its own setting. A misaligned effective address raises no error. The unit returns a defined filler value instead, which is the aligned word that contains the address, arranged in the captured byte order. The write port shows the result three cycles after issue, whatever the traffic.

Top module: `guarded_load_unit`

## Requirements
- R1: On the clock edge that samples an issued operation with guard bit 0 set, the unit computes an effective address EA = base + 4 * sign-extended displacement, modulo 2^32. On the next cycle it raises `mem_req` for exactly one cycle, with `mem_addr` equal to EA with bits [1:0] cleared.
- R2: The displacement field is two's complement. Code 7'h40 gives a byte offset of -256 and code 7'h3F gives +252. Both ends of this range address memory correctly.
- R3: An operation whose guard bit 0 is 1 raises `wb_en` for exactly one cycle, three cycles after its issue cycle, with `wb_dest` equal to its destination index.
- R4: An operation whose guard bit 0 is 0 raises neither `mem_req` nor `wb_en`. Guard bits 31 to 1 have no effect.
- R5: The memory port delivers `mem_rdata` one cycle after a request, with bits [8k+7:8k] holding the byte at address `mem_addr`+k. In little-endian mode (`issue_big_endian` = 0), result bits [8k+7:8k] hold the byte at EA+k.
- R6: In big-endian mode (`issue_big_endian` = 1), result bits [8k+7:8k] hold the byte at EA+3-k. For example, bytes 0x84, 0x33, 0x22, 0x11 at addresses 0xd00 to 0xd03 load as 0x84332211.
- R7: The byte-order mode is sampled in the issue cycle. Changing it afterwards does not alter operations already in flight.
- R8: When EA[1:0] is not 0, the write still takes place three cycles after issue. Its data is the word at EA with bits [1:0] cleared, arranged by the sampled byte order, and no error indication exists.
- R9: Operations issued on consecutive cycles each complete in their own slot with their own destination, data and byte order.
- R10: While `rst_n` is low, `mem_req` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An operation is offered this cycle |
| issue_base | input | 32 | Base register value |
| issue_disp | input | 7 | Signed displacement in words |
| issue_guard | input | 32 | Guard value; only bit 0 is used |
| issue_dest | input | 7 | Destination register index |
| issue_big_endian | input | 1 | Byte order for this operation, 1 = big-endian |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Word-aligned byte address of the read |
| mem_rdata | input | 32 | Raw read word, one cycle after `mem_req` |
| wb_en | output | 1 | Register-file write enable |
| wb_dest | output | 7 | Register-file write index |
| wb_data | output | 32 | Register-file write data |

## Verification
The bound assertions assume that the memory is synchronous with one cycle of latency. They also assume that `mem_rdata` changes only as the answer to a request, so that the sampled read word can be related to the result two edges later. Issue inputs are taken to be held steady from edge to edge and to be low during reset. The bench drives every input on the falling clock edge. Its memory model registers the read word only when `mem_req` is high, and it never writes memory while the run is going, so these assumptions hold throughout. The misaligned case is checked against the defined filler word, not treated as a don't-care.

// File: rtl/glu_pkg.sv
package glu_pkg;
    // Width of one byte lane in the data path.
    localparam int unsigned LANE_W = 8;
    // Number of low address bits that select a byte inside a word.
    localparam int unsigned WORD_SHIFT = 2;

    // Byte order captured with each load.
    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;
endpackage

// File: rtl/glu_addr_gen.sv
// Issue stage: builds the word-aligned effective address and registers the
// operation's control fields.
// The displacement is always a whole number of words, so EA[1:0] equals
// base[1:0]. The adder therefore works on word addresses only and drops the
// two low bits. An operation with a false guard updates no payload register.
module glu_addr_gen
    import glu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DISP_W = 7,
    parameter int unsigned DEST_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [ADDR_W-1:0] issue_base,
    input  logic [DISP_W-1:0] issue_disp,
    input  logic              issue_guard_lsb,
    input  logic [DEST_W-1:0] issue_dest,
    input  byte_order_e       issue_order,
    output logic              a_fire,
    output logic [ADDR_W-1:0] a_word_addr,
    output logic [DEST_W-1:0] a_dest,
    output byte_order_e       a_order
);
    localparam int unsigned WADDR_W = ADDR_W - WORD_SHIFT;
    localparam int unsigned EXT_W   = WADDR_W - DISP_W;

    logic               take;
    logic [WADDR_W-1:0] disp_words;
    logic [WADDR_W-1:0] ea_words;
    logic [1:0]         unused_base_lsbs;

    // Decide whether the offered operation has any effect.
    assign take = issue_valid & issue_guard_lsb;

    // Sign-extend the word displacement and add it to the base word address.
    always_comb begin
        disp_words = {{EXT_W{issue_disp[DISP_W-1]}}, issue_disp};
        ea_words   = issue_base[ADDR_W-1:WORD_SHIFT] + disp_words;
    end

    assign unused_base_lsbs = issue_base[WORD_SHIFT-1:0];

    // Register the strobe, and capture the payload only for live operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_fire      <= 1'b0;
            a_word_addr <= '0;
            a_dest      <= '0;
            a_order     <= ORDER_LITTLE;
        end else begin
            a_fire <= take;
            if (take) begin
                a_word_addr <= {ea_words, {WORD_SHIFT{1'b0}}};
                a_dest      <= issue_dest;
                a_order     <= issue_order;
            end
        end
    end
endmodule

// File: rtl/glu_meta_delay.sv
// Valid-qualified delay line that carries an operation's control fields
// alongside the memory access. The payload moves only together with a valid,
// so idle cycles do not toggle it. STAGES must be at least 1.
module glu_meta_delay #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    logic             vld [STAGES+1];
    logic [WIDTH-1:0] dat [STAGES+1];

    assign vld[0] = in_valid;
    assign dat[0] = in_data;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Advance one stage; hold the payload while the slot is empty.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[s+1] <= 1'b0;
                dat[s+1] <= '0;
            end else begin
                vld[s+1] <= vld[s];
                if (vld[s]) begin
                    dat[s+1] <= dat[s];
                end
            end
        end
    end

    assign out_valid = vld[STAGES];
    assign out_data  = dat[STAGES];
endmodule

// File: rtl/glu_byte_order.sv
// Combinational lane steering. The raw word holds the byte at the lowest
// address in lane 0. Little-endian passes the lanes straight through;
// big-endian mirrors them.
module glu_byte_order
    import glu_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic [LANES*LANE_W-1:0] raw_word,
    input  byte_order_e             order,
    output logic [LANES*LANE_W-1:0] arranged
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Pick the source lane for result lane k.
        assign arranged[k*LANE_W +: LANE_W] = (order == ORDER_BIG)
            ? raw_word[(LANES-1-k)*LANE_W +: LANE_W]
            : raw_word[k*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/guarded_load_unit.sv
// Guarded displacement load unit.
// Edge 0 samples the operation and registers the aligned address, which is
// presented as the memory request. Edge 1 is the memory's own read register.
// Edge 2 registers the lane-steered result onto the write port. The memory
// is assumed synchronous with MEM_LAT cycles of read latency.
module guarded_load_unit
    import glu_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned DISP_W  = 7,
    parameter int unsigned DEST_W  = 7,
    parameter int unsigned GUARD_W = 32,
    parameter int unsigned MEM_LAT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [ADDR_W-1:0]  issue_base,
    input  logic [DISP_W-1:0]  issue_disp,
    input  logic [GUARD_W-1:0] issue_guard,
    input  logic [DEST_W-1:0]  issue_dest,
    input  logic               issue_big_endian,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               wb_en,
    output logic [DEST_W-1:0]  wb_dest,
    output logic [DATA_W-1:0]  wb_data
);
    localparam int unsigned LANES  = DATA_W / LANE_W;
    localparam int unsigned META_W = DEST_W + 1;

    logic              a_fire;
    logic [ADDR_W-1:0] a_word_addr;
    logic [DEST_W-1:0] a_dest;
    byte_order_e       a_order;
    logic              m_valid;
    logic [META_W-1:0] m_meta;
    byte_order_e       m_order;
    logic [DATA_W-1:0] steered;
    logic              unused_guard_bits;

    // Only guard bit 0 is meaningful.
    assign unused_guard_bits = ^issue_guard[GUARD_W-1:1];

    glu_addr_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .DEST_W (DEST_W)
    ) u_addr_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .issue_valid     (issue_valid),
        .issue_base      (issue_base),
        .issue_disp      (issue_disp),
        .issue_guard_lsb (issue_guard[0]),
        .issue_dest      (issue_dest),
        .issue_order     (byte_order_e'(issue_big_endian)),
        .a_fire          (a_fire),
        .a_word_addr     (a_word_addr),
        .a_dest          (a_dest),
        .a_order         (a_order)
    );

    // The memory request comes straight from the issue-stage registers.
    assign mem_req  = a_fire;
    assign mem_addr = a_word_addr;

    glu_meta_delay #(
        .WIDTH  (META_W),
        .STAGES (MEM_LAT)
    ) u_meta_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (a_fire),
        .in_data   ({a_dest, a_order}),
        .out_valid (m_valid),
        .out_data  (m_meta)
    );

    assign m_order = byte_order_e'(m_meta[0]);

    glu_byte_order #(
        .LANES (LANES)
    ) u_byte_order (
        .raw_word (mem_rdata),
        .order    (m_order),
        .arranged (steered)
    );

    // Write-port register: the result appears three cycles after issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en   <= 1'b0;
            wb_dest <= '0;
            wb_data <= '0;
        end else begin
            wb_en <= m_valid;
            if (m_valid) begin
                wb_dest <= m_meta[META_W-1:1];
                wb_data <= steered;
            end
        end
    end
endmodule

// File: rtl/glu_checker.sv
// Property checker for guarded_load_unit. It observes only the top-level
// ports and assumes a one-cycle synchronous memory whose read word changes
// only in answer to a request.
module glu_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned DISP_W  = 7,
    parameter int unsigned DEST_W  = 7,
    parameter int unsigned GUARD_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid,
    input logic [ADDR_W-1:0]  issue_base,
    input logic [DISP_W-1:0]  issue_disp,
    input logic [GUARD_W-1:0] issue_guard,
    input logic [DEST_W-1:0]  issue_dest,
    input logic               issue_big_endian,
    input logic               mem_req,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_rdata,
    input logic               wb_en,
    input logic [DEST_W-1:0]  wb_dest,
    input logic [DATA_W-1:0]  wb_data
);
    localparam int unsigned NBYTES = DATA_W / 8;

    function automatic logic [ADDR_W-1:0] full_ea(input logic [ADDR_W-1:0] b,
                                                  input logic [DISP_W-1:0] d);
        logic [ADDR_W-1:0] off;
        off = ADDR_W'($signed(d)) <<< 2;
        return (b + off) & ~ADDR_W'(3);
    endfunction

    function automatic logic [DATA_W-1:0] swap(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < NBYTES; i++) begin
            r[8*i +: 8] = w[8*(NBYTES-1-i) +: 8];
        end
        return r;
    endfunction

    logic issue_live;
    assign issue_live = issue_valid & issue_guard[0];

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !wb_en));

    assert_req_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_live |=> (mem_req && mem_addr == full_ea($past(issue_base), $past(issue_disp))));

    assert_req_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_guard_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_live |=> !mem_req);

    assert_wb_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(mem_req, 2));

    assert_wb_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_req, 2) |-> wb_en);

    assert_wb_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_dest == $past(issue_dest, 3)));

    assert_little_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !$past(issue_big_endian, 3)) |-> (wb_data == $past(mem_rdata)));

    assert_big_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && $past(issue_big_endian, 3)) |-> (wb_data == swap($past(mem_rdata))));
endmodule

bind guarded_load_unit glu_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DISP_W  (DISP_W),
    .DEST_W  (DEST_W),
    .GUARD_W (GUARD_W)
) u_glu_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .issue_valid      (issue_valid),
    .issue_base       (issue_base),
    .issue_disp       (issue_disp),
    .issue_guard      (issue_guard),
    .issue_dest       (issue_dest),
    .issue_big_endian (issue_big_endian),
    .mem_req          (mem_req),
    .mem_addr         (mem_addr),
    .mem_rdata        (mem_rdata),
    .wb_en            (wb_en),
    .wb_dest          (wb_dest),
    .wb_data          (wb_data)
);

// File: tb/guarded_load_unit_tb.sv
`timescale 1ns/1ps
module guarded_load_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [31:0] issue_base;
    logic [6:0]  issue_disp;
    logic [31:0] issue_guard;
    logic [6:0]  issue_dest;
    logic        issue_big_endian;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        wb_en;
    logic [6:0]  wb_dest;
    logic [31:0] wb_data;

    always #2 clk = ~clk;

    guarded_load_unit u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .issue_valid      (issue_valid),
        .issue_base       (issue_base),
        .issue_disp       (issue_disp),
        .issue_guard      (issue_guard),
        .issue_dest       (issue_dest),
        .issue_big_endian (issue_big_endian),
        .mem_req          (mem_req),
        .mem_addr         (mem_addr),
        .mem_rdata        (mem_rdata),
        .wb_en            (wb_en),
        .wb_dest          (wb_dest),
        .wb_data          (wb_data)
    );

    // Byte-addressed memory model, 4 KiB, one-cycle synchronous read.
    logic [7:0] mem_b [0:4095];
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= {mem_b[{mem_addr[11:2], 2'd3}], mem_b[{mem_addr[11:2], 2'd2}],
                          mem_b[{mem_addr[11:2], 2'd1}], mem_b[{mem_addr[11:2], 2'd0}]};
        end
    end

    typedef struct {
        int          due;
        logic [6:0]  dest;
        logic [31:0] data;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_wb[$];
    exp_t exp_rq[$];
    int   cyc = 0;
    int   vectors = 0;
    int   fails = 0;
    bit   started = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Reference result: aligned word, byte lanes placed by the sampled order.
    function automatic logic [31:0] model(input logic [31:0] ea, input logic big);
        logic [31:0] r;
        logic [11:0] a;
        for (int k = 0; k < 4; k++) begin
            a = {ea[11:2], 2'b00} + 12'(k);
            if (big) r[8*(3-k) +: 8] = mem_b[a];
            else     r[8*k +: 8]     = mem_b[a];
        end
        return r;
    endfunction

    task automatic issue(input logic [31:0] base, input logic [6:0] disp,
                         input logic [31:0] guard, input logic [6:0] dest,
                         input logic big, input string tag);
        logic [31:0] ea;
        exp_t e;
        @(negedge clk);
        issue_valid      = 1'b1;
        issue_base       = base;
        issue_disp       = disp;
        issue_guard      = guard;
        issue_dest       = dest;
        issue_big_endian = big;
        ea = base + ({{25{disp[6]}}, disp} << 2);
        if (guard[0]) begin
            e.due = cyc + 1; e.dest = dest; e.data = 0; e.addr = ea & ~32'h3; e.tag = "R1";
            exp_rq.push_back(e);
            e.due = cyc + 3; e.data = model(ea, big); e.tag = tag;
            exp_wb.push_back(e);
        end
    endtask

    // Idle cycles; the order input is flipped each time to probe R7.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_valid      = 1'b0;
            issue_guard      = 32'h1;
            issue_big_endian = ~issue_big_endian;
        end
    endtask

    // Cycle-by-cycle comparison against the expectation queues.
    always @(negedge clk) begin
        if (started) begin
            if (exp_rq.size() > 0 && exp_rq[0].due == cyc) begin
                chk("R1", "mem_req", {31'd0, mem_req}, 32'd1);
                chk("R1", "mem_addr", mem_addr, exp_rq[0].addr);
                void'(exp_rq.pop_front());
            end else begin
                chk("R4", "idle mem_req", {31'd0, mem_req}, 32'd0);
            end
            if (exp_wb.size() > 0 && exp_wb[0].due == cyc) begin
                chk(exp_wb[0].tag, "wb_en", {31'd0, wb_en}, 32'd1);
                chk(exp_wb[0].tag, "wb_dest", {25'd0, wb_dest}, {25'd0, exp_wb[0].dest});
                chk(exp_wb[0].tag, "wb_data", wb_data, exp_wb[0].data);
                void'(exp_wb.pop_front());
            end else begin
                chk("R3", "idle wb_en", {31'd0, wb_en}, 32'd0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem_b[i] = 8'((i * 37 + 11) ^ (i >> 3));
        mem_b[12'hd00] = 8'h84; mem_b[12'hd01] = 8'h33;
        mem_b[12'hd02] = 8'h22; mem_b[12'hd03] = 8'h11;
        mem_b[12'hd04] = 8'h48; mem_b[12'hd05] = 8'h66;
        mem_b[12'hd06] = 8'h55; mem_b[12'hd07] = 8'h44;
        rst_n = 1'b0; issue_valid = 1'b0; issue_base = '0; issue_disp = '0;
        issue_guard = '0; issue_dest = '0; issue_big_endian = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R10", "reset wb_en", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;
        started = 1'b1;

        // R6: big-endian example, 0xcfc + 4 -> 0x84332211; R5 same word little.
        issue(32'hcfc, 7'd1, 32'h1, 7'd10, 1'b1, "R6");
        idle(3);
        issue(32'hcfc, 7'd1, 32'h1, 7'd11, 1'b0, "R5");
        idle(3);
        // R4: guard bit 0 clear (also with all upper bits set) does nothing.
        issue(32'hd0c, 7'h7E, 32'h0, 7'd20, 1'b1, "R4");
        issue(32'hd0c, 7'h7E, 32'hFFFF_FFFE, 7'd21, 1'b1, "R4");
        issue(32'hd0c, 7'h7E, 32'h1, 7'd22, 1'b1, "R6");
        idle(4);
        // R2: displacement extremes -256 and +252.
        issue(32'h400, 7'h40, 32'h1, 7'd30, 1'b0, "R2");
        issue(32'h400, 7'h3F, 32'h1, 7'd31, 1'b1, "R2");
        idle(4);
        // R8: misaligned EA 0xcf9 returns the word at 0xcf8.
        issue(32'hd01, 7'h7E, 32'h1, 7'd40, 1'b1, "R8");
        issue(32'hd02, 7'h01, 32'h3, 7'd41, 1'b0, "R8");
        idle(4);
        // R7: order flips on the cycles after issue while loads are in flight.
        issue(32'h200, 7'd3, 32'h1, 7'd50, 1'b1, "R7");
        idle(1);
        issue(32'h204, 7'd3, 32'h1, 7'd51, 1'b0, "R7");
        idle(1);
        // R9: back-to-back stream with mixed guards, orders and alignments.
        for (int i = 0; i < 40; i++) begin
            issue($urandom_range(0, 4095), 7'($urandom), 32'($urandom),
                  7'($urandom), 1'($urandom), "R9");
        end
        idle(6);
        chk("R9", "pending writes", exp_wb.size(), 0);
        chk("R9", "pending reads", exp_rq.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule